// File: doc/BRIEF.md
# Burst SRAM Access and Write Control

This block is the synchronous command front-end of a flow-through burst SRAM that shares one bidirectional data bus for reads and writes. At every rising clock edge it samples three chip selects, two competing address strobes (one issued by a processor, one by a cache controller), a global write enable, a byte-write enable and one byte select per data byte. From these it classifies the cycle as a new read, a new write, a burst continuation or a deselect. It then drives a one-clock address-load pulse, a one-clock burst-advance pulse, per-byte write strobes to the memory array, and the enable for the data-bus drivers.

The two strobes follow different rules. The processor strobe wins whenever it is honoured, but it is blocked by the first chip select alone. It never writes in its first cycle: a processor write takes its write enables on the following edge. The controller strobe decides read or write from the write inputs sampled with it. The address counter and the power-down logic sit in separate blocks that consume the load and advance pulses.

The bus-driver enable is registered cycle state, gated combinationally by an asynchronous active-low output enable. A read drives the bus in the same cycle as the address load, with no pipeline stage. Every pin here is a plain control level, so no valid/ready handshake exists and the block applies no back-pressure. Each edge is taken as a command.

Top module: `bsram_access_ctrl`

## Requirements
- R1: A strobe that is honoured starts an access (addr_load high for the cycle after the edge) only if sel1_n=0, sel2=1 and sel3_n=0 at that edge. Otherwise it is a deselect: addr_load, burst_adv and wr_stb stay 0, and the open burst ends.
- R2: The processor strobe pstb_n is ignored whenever sel1_n is 1.
- R3: When pstb_n is 0 and honoured, the controller strobe cstb_n has no effect.
- R4: A controller-strobed start is a write in its first cycle if the write inputs indicate a write at that edge. Otherwise it is a read.
- R5: A processor-strobed start never writes in its first cycle, whatever the write inputs. It reads in that cycle. At the next edge, with no strobe, the write inputs sampled there produce the write.
- R6: gwr_n=0 writes every byte: wr_stb is all ones, regardless of bwr_en_n and bsel_n.
- R7: With gwr_n=1, byte i is written only when bwr_en_n=0 and bsel_n[i]=0. A cycle that writes no byte is a read.
- R8: bus_oe is 0 during any cycle with a nonzero wr_stb, whatever oe_n is.
- R9: In a read cycle, bus_oe equals the inverse of oe_n and follows it without a clock. It is high in the same cycle as addr_load for a read start, and it is 0 in idle cycles.
- R10: Each write strobe lasts exactly one clock. It is 0 in the cycle after an edge that carries no write.
- R11: While a burst is open and no strobe is honoured, adv_n=0 gives a one-clock burst_adv pulse and adv_n=1 holds the address. Either way the cycle reads or writes by the write inputs. With no burst open, the edge does nothing.
- R12: While rst_n is 0, all outputs are 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel1_n | input | 1 | First chip select, active low; also gates the processor strobe |
| sel2 | input | 1 | Second chip select, active high |
| sel3_n | input | 1 | Third chip select, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance request, active low |
| gwr_n | input | 1 | Global write enable, active low |
| bwr_en_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NUM_BYTES | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr_load | output | 1 | One-clock pulse: load the sampled address into the burst counter |
| burst_adv | output | 1 | One-clock pulse: step the burst counter |
| wr_stb | output | NUM_BYTES | Per-byte write strobes to the array |
| bus_oe | output | 1 | Data-bus driver enable |

## Verification
The bench sweeps every combination of the twelve sampled inputs, once from an idle state and once from a freshly opened processor burst. This reaches the edges where both strobes are low, where the processor strobe is low but the first select is high, and where only the second or third select is off. A design that let the processor strobe through with sel1_n high, or let the controller strobe override it, would show a stray addr_load or write. A design that wrote on the processor strobe's own edge would strobe the array one cycle early. Flipping oe_n within each cycle exposes a bus enable that is registered instead of asynchronous, and one that drives during a byte write. Checking the cycle after every sweep point catches a write strobe that lingers past one clock.

// File: rtl/bsram_ctrl_pkg.sv
package bsram_ctrl_pkg;

  // Outcome of the strobe arbitration at one clock edge
  typedef enum logic [1:0] {
    START_NONE  = 2'd0,  // no strobe honoured: continue or stay idle
    START_PROC  = 2'd1,  // processor-strobed access begins
    START_CTRL  = 2'd2,  // controller-strobed access begins
    START_DESEL = 2'd3   // a strobe was honoured but the chip is not selected
  } start_e;

endpackage

// File: rtl/bsram_strobe_arb.sv
module bsram_strobe_arb
  import bsram_ctrl_pkg::*;
(
  input  logic   sel1_n,
  input  logic   sel2,
  input  logic   sel3_n,
  input  logic   pstb_n,
  input  logic   cstb_n,
  output start_e start_kind
);

  logic sel_ok;
  logic proc_hit;
  logic ctrl_hit;

  // all three selects must agree before any access may begin
  assign sel_ok   = ~sel1_n & sel2 & ~sel3_n;
  // processor strobe only counts while the first select is low
  assign proc_hit = ~pstb_n & ~sel1_n;
  // controller strobe loses to an honoured processor strobe
  assign ctrl_hit = ~cstb_n & ~proc_hit;

  always_comb begin
    start_kind = START_NONE;
    if (proc_hit) begin
      start_kind = sel_ok ? START_PROC : START_DESEL;
    end else if (ctrl_hit) begin
      start_kind = sel_ok ? START_CTRL : START_DESEL;
    end
  end

endmodule

// File: rtl/bsram_byte_wr_dec.sv
module bsram_byte_wr_dec #(
  parameter int NUM_BYTES = 4
) (
  input  logic                 gwr_n,
  input  logic                 bwr_en_n,
  input  logic [NUM_BYTES-1:0] bsel_n,
  output logic [NUM_BYTES-1:0] wr_mask,
  output logic                 wr_any
);

  // one lane per byte: global enable wins, else enable AND select
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    assign wr_mask[b] = ~gwr_n | (~bwr_en_n & ~bsel_n[b]);
  end

  assign wr_any = |wr_mask;

endmodule

// File: rtl/bsram_cycle_seq.sv
module bsram_cycle_seq
  import bsram_ctrl_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  start_e               start_kind,
  input  logic                 adv_n,
  input  logic [NUM_BYTES-1:0] wr_mask,
  input  logic                 wr_any,
  output logic                 addr_load,
  output logic                 burst_adv,
  output logic                 rd_cycle,
  output logic [NUM_BYTES-1:0] wr_stb
);

  logic                 open_q;
  logic                 open_d;
  logic                 load_d;
  logic                 adv_d;
  logic                 rd_d;
  logic [NUM_BYTES-1:0] wr_d;

  always_comb begin
    open_d = open_q;
    load_d = 1'b0;
    adv_d  = 1'b0;
    rd_d   = 1'b0;
    wr_d   = '0;
    unique case (start_kind)
      START_PROC: begin
        // write inputs are not looked at on this edge
        open_d = 1'b1;
        load_d = 1'b1;
        rd_d   = 1'b1;
      end
      START_CTRL: begin
        open_d = 1'b1;
        load_d = 1'b1;
        wr_d   = wr_mask;
        rd_d   = ~wr_any;
      end
      START_DESEL: begin
        open_d = 1'b0;
      end
      default: begin
        if (open_q) begin
          adv_d = ~adv_n;
          wr_d  = wr_mask;
          rd_d  = ~wr_any;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      addr_load <= 1'b0;
      burst_adv <= 1'b0;
      rd_cycle  <= 1'b0;
      wr_stb    <= '0;
    end else begin
      open_q    <= open_d;
      addr_load <= load_d;
      burst_adv <= adv_d;
      rd_cycle  <= rd_d;
      wr_stb    <= wr_d;
    end
  end

endmodule

// File: rtl/bsram_access_ctrl.sv
module bsram_access_ctrl
  import bsram_ctrl_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel1_n,
  input  logic                 sel2,
  input  logic                 sel3_n,
  input  logic                 pstb_n,
  input  logic                 cstb_n,
  input  logic                 adv_n,
  input  logic                 gwr_n,
  input  logic                 bwr_en_n,
  input  logic [NUM_BYTES-1:0] bsel_n,
  input  logic                 oe_n,
  output logic                 addr_load,
  output logic                 burst_adv,
  output logic [NUM_BYTES-1:0] wr_stb,
  output logic                 bus_oe
);

  start_e               start_kind;
  logic [NUM_BYTES-1:0] wr_mask;
  logic                 wr_any;
  logic                 rd_cycle;

  bsram_strobe_arb u_arb (
    .sel1_n     (sel1_n),
    .sel2       (sel2),
    .sel3_n     (sel3_n),
    .pstb_n     (pstb_n),
    .cstb_n     (cstb_n),
    .start_kind (start_kind)
  );

  bsram_byte_wr_dec #(.NUM_BYTES(NUM_BYTES)) u_wdec (
    .gwr_n    (gwr_n),
    .bwr_en_n (bwr_en_n),
    .bsel_n   (bsel_n),
    .wr_mask  (wr_mask),
    .wr_any   (wr_any)
  );

  bsram_cycle_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_kind (start_kind),
    .adv_n      (adv_n),
    .wr_mask    (wr_mask),
    .wr_any     (wr_any),
    .addr_load  (addr_load),
    .burst_adv  (burst_adv),
    .rd_cycle   (rd_cycle),
    .wr_stb     (wr_stb)
  );

  // drivers on only for a read with oe_n low; any write strobe forces them off
  assign bus_oe = rd_cycle & ~oe_n & ~(|wr_stb);

endmodule

// File: rtl/bsram_access_ctrl_chk.sv
module bsram_access_ctrl_chk #(
  parameter int NUM_BYTES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sel1_n,
  input logic                 sel2,
  input logic                 sel3_n,
  input logic                 pstb_n,
  input logic                 cstb_n,
  input logic                 gwr_n,
  input logic                 bwr_en_n,
  input logic                 oe_n,
  input logic                 addr_load,
  input logic                 burst_adv,
  input logic [NUM_BYTES-1:0] wr_stb,
  input logic                 bus_oe
);

  p_write_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb) |-> !bus_oe);

  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !bus_oe);

  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel1_n && !(sel2 && !sel3_n) && (!pstb_n || !cstb_n))
      |=> (!addr_load && !burst_adv && wr_stb == '0));

  p_sel1_masks_proc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel1_n && cstb_n) |=> !addr_load);

  p_proc_first_nowr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && !sel1_n) |=> (wr_stb == '0 && !burst_adv));

  p_ctrl_global_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel1_n && sel2 && !sel3_n && pstb_n && !cstb_n && !gwr_n)
      |=> (&wr_stb));

  p_ctrl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel1_n && sel2 && !sel3_n && pstb_n && !cstb_n && gwr_n && bwr_en_n)
      |=> (addr_load && wr_stb == '0));

endmodule

bind bsram_access_ctrl bsram_access_ctrl_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel1_n    (sel1_n),
  .sel2      (sel2),
  .sel3_n    (sel3_n),
  .pstb_n    (pstb_n),
  .cstb_n    (cstb_n),
  .gwr_n     (gwr_n),
  .bwr_en_n  (bwr_en_n),
  .oe_n      (oe_n),
  .addr_load (addr_load),
  .burst_adv (burst_adv),
  .wr_stb    (wr_stb),
  .bus_oe    (bus_oe)
);

// File: tb/bsram_access_ctrl_test.sv
module bsram_access_ctrl_test;

  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic          pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
  logic          gwr_n = 1'b1, bwr_en_n = 1'b1, oe_n = 1'b1;
  logic [NB-1:0] bsel_n = '1;
  logic          addr_load, burst_adv, bus_oe;
  logic [NB-1:0] wr_stb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bsram_access_ctrl #(.NUM_BYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gwr_n(gwr_n),
    .bwr_en_n(bwr_en_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .addr_load(addr_load), .burst_adv(burst_adv), .wr_stb(wr_stb), .bus_oe(bus_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one edge with the given inputs; returns after the edge, away from it
  task automatic step(input logic [11:0] v);
    @(negedge clk);
    sel1_n = v[0]; sel2 = v[1]; sel3_n = v[2]; pstb_n = v[3]; cstb_n = v[4];
    gwr_n = v[5]; bwr_en_n = v[6]; bsel_n = v[10:7]; adv_n = v[11];
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    #23;
    check("R12", "addr_load", {3'b0, addr_load}, '0);
    check("R12", "burst_adv", {3'b0, burst_adv}, '0);
    check("R12", "wr_stb", wr_stb, '0);
    oe_n = 1'b0; #1;
    check("R12", "bus_oe", {3'b0, bus_oe}, '0);
    rst_n = 1'b1;

    for (int st = 0; st < 2; st++) begin
      for (int k = 0; k < 4096; k++) begin
        logic [11:0] v;
        logic c1, c2, c3, ps, cs, gw, bw, an, sel, pe, ce, wd, prior;
        logic [NB-1:0] wb, e_wr;
        logic e_load, e_adv, e_rd;
        string lab_load, lab_wr;
        v = 12'(k);
        prior = (st == 1);
        // setup edge: deselect (idle) or processor-strobed start (burst open)
        oe_n = 1'b0;
        if (prior) step(12'b1111_1111_0010);
        else       step(12'b1111_1110_1111);
        check("R10", "wr_stb after setup", wr_stb, '0);
        check(prior ? "R5" : "R1", "setup load", {3'b0, addr_load}, {3'b0, prior});
        check(prior ? "R9" : "R9", "setup bus_oe", {3'b0, bus_oe}, {3'b0, prior});

        step(v);
        c1 = v[0]; c2 = v[1]; c3 = v[2]; ps = v[3]; cs = v[4];
        gw = v[5]; bw = v[6]; an = v[11];
        sel = ~c1 & c2 & ~c3;
        pe  = ~ps & ~c1;
        ce  = ~cs & ~pe;
        wb  = !gw ? '1 : (!bw ? ~v[10:7] : '0);
        wd  = |wb;
        e_load = 1'b0; e_adv = 1'b0; e_rd = 1'b0; e_wr = '0;
        if (pe) begin
          if (sel) begin e_load = 1'b1; e_rd = 1'b1; end
        end else if (ce) begin
          if (sel) begin e_load = 1'b1; e_wr = wb; e_rd = ~wd; end
        end else if (prior) begin
          e_adv = ~an; e_wr = wb; e_rd = ~wd;
        end
        lab_load = (!ps && c1) ? "R2" : ((!ps && !cs) ? "R3" : "R1");
        lab_wr   = pe ? "R5" : (ce ? (!gw ? "R6" : "R4") : (!gw ? "R6" : "R7"));
        check(lab_load, "addr_load", {3'b0, addr_load}, {3'b0, e_load});
        check("R11", "burst_adv", {3'b0, burst_adv}, {3'b0, e_adv});
        check(lab_wr, "wr_stb", wr_stb, e_wr);
        check(wd && (e_wr != '0) ? "R8" : "R9", "bus_oe oe low",
              {3'b0, bus_oe}, {3'b0, e_rd});
        oe_n = 1'b1; #1;
        check("R9", "bus_oe oe high", {3'b0, bus_oe}, '0);
        oe_n = 1'b0; #1;
        check("R9", "bus_oe oe back low", {3'b0, bus_oe}, {3'b0, e_rd});
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule